// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits in front of an embedded flash array. It watches the write cycles on a simple synchronous bus and matches them against multi-cycle unlock and command sequences. From those sequences it chooses what a bus read returns: array data in normal read mode, an identification code in ID mode, or a status byte while an automatic erase is running. It also drives a ready/busy bit. The erase itself is modelled by an internal down-counter that holds the block busy for a fixed, parameterised number of cycles.

The two unlock cycles are data 0xAA at address `UNLOCK_A1` (0x5555) followed by data 0x55 at address `UNLOCK_A2` (0x2AAA). The third cycle carries the command byte. A write of 0xF0 is a reset command at any point, and it cancels any sequence that is partly entered. ID mode is sticky. Code-select writes may repeat with no fresh unlock. An erase, once started, can only be aborted by the hardware reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After hardware reset, ready_o is 1, erase_op_o is 0, id_mode_o is 0, and reads return array data.
- R2: In read mode, a read strobe captures array_data_i. The value appears on rdata_o one cycle after the strobe.
- R3: Three writes enter ID mode: 0xAA@0x5555, then 0x55@0x2AAA, then 0x90@0x5555. Reads at any address then return the flash type code (select 0) until a code-select write arrives.
- R4: In ID mode, a write that is neither 0xF0 nor 0xAA@0x5555 is a code-select write. Its wdata_i[1:0] chooses the code returned by later reads: 0 = type, 1 = maker, 2 = device, 3 = macro. This may repeat any number of times with no unlock.
- R5: ID mode persists across any number of reads and code selects. Only three things leave it: a single 0xF0 write, the three-cycle 0xAA@0x5555, 0x55@0x2AAA, 0xF0 sequence, or a hardware reset.
- R6: A write that does not match the expected next cycle of a sequence drops the matcher back to idle. The mode and the selected code do not change.
- R7: A 0xF0 write at any stage of a partly entered sequence cancels it and puts the block in read mode.
- R8: Six writes start an erase: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then a final write. The final write selects the operation: 0x10@0x5555 gives chip erase (erase_op_o = 1), 0x30 at any address gives block erase (2), and 0x60@0x5555 gives protect erase (3). ready_o is 0 for exactly ERASE_CYCLES cycles after the final write. It then returns to 1, erase_op_o returns to 0, and the block is in read mode.
- R9: While busy, all writes are ignored, including 0xF0 and complete command sequences. The erase keeps its full length and its operation code.
- R10: While busy, a read returns the status byte: bit 7 = ready (0), bits 1:0 = operation code, all other bits 0.
- R11: Asserting rst_ni during an erase aborts it. ready_o is 1 and erase_op_o is 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | AW | Bus address |
| wdata_i | input | 8 | Bus write data |
| array_data_i | input | 8 | Data from the flash array at addr_i |
| rdata_o | output | 8 | Registered read data |
| ready_o | output | 1 | 1 = ready, 0 = automatic operation running |
| erase_op_o | output | 2 | Running operation: 0 none, 1 chip, 2 block, 3 protect |
| id_mode_o | output | 1 | 1 while in ID mode |

## Verification
Mode changes and the start of an erase take effect on the clock edge that captures the deciding write. They are visible at the next falling edge, and the bench samples there. Read data is registered, so the bench drives rd_i for one cycle and checks rdata_o at the falling edge after the capturing edge. The erase length is measured as a cycle count. It runs from the edge of the final sequence write to the first falling edge that sees ready_o high, and it must equal ERASE_CYCLES even when reads and writes are inserted during the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_E1, SQ_E2, SQ_E3} seq_state_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_CHIP = 2'd1, OP_BLOCK = 2'd2, OP_PROT = 2'd3} erase_op_e;
  typedef enum logic {MD_ARRAY = 1'b0, MD_ID = 1'b1} rd_mode_e;

  localparam logic [7:0] K_UNLOCK1 = 8'hAA;
  localparam logic [7:0] K_UNLOCK2 = 8'h55;
  localparam logic [7:0] K_RESET   = 8'hF0;
  localparam logic [7:0] K_ID      = 8'h90;
  localparam logic [7:0] K_ERASE   = 8'h80;
  localparam logic [7:0] K_CHIP    = 8'h10;
  localparam logic [7:0] K_BLOCK   = 8'h30;
  localparam logic [7:0] K_PROT    = 8'h60;
endpackage

// File: rtl/flash_seq_match.sv
module flash_seq_match
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] UNLOCK_A1 = AW'(16'h5555),
  parameter logic [AW-1:0] UNLOCK_A2 = AW'(16'h2AAA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          ev_reset_o,
  output logic          ev_id_o,
  output logic          ev_erase_o,
  output erase_op_e     erase_kind_o,
  output logic          ev_other_o
);
  seq_state_e st_q, st_d;
  logic at_a1, at_a2;

  assign at_a1 = (addr_i == UNLOCK_A1);
  assign at_a2 = (addr_i == UNLOCK_A2);

  always_comb begin
    st_d         = st_q;
    ev_reset_o   = 1'b0;
    ev_id_o      = 1'b0;
    ev_erase_o   = 1'b0;
    erase_kind_o = OP_NONE;
    ev_other_o   = 1'b0;
    if (wr_i && en_i) begin
      st_d = SQ_IDLE;
      if (wdata_i == K_RESET) begin
        ev_reset_o = 1'b1;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (at_a1 && wdata_i == K_UNLOCK1) st_d = SQ_U1;
            else ev_other_o = 1'b1;
          end
          SQ_U1: if (at_a2 && wdata_i == K_UNLOCK2) st_d = SQ_U2;
          SQ_U2: begin
            if (at_a1 && wdata_i == K_ID) ev_id_o = 1'b1;
            else if (at_a1 && wdata_i == K_ERASE) st_d = SQ_E1;
          end
          SQ_E1: if (at_a1 && wdata_i == K_UNLOCK1) st_d = SQ_E2;
          SQ_E2: if (at_a2 && wdata_i == K_UNLOCK2) st_d = SQ_E3;
          SQ_E3: begin
            if (at_a1 && wdata_i == K_CHIP) begin
              ev_erase_o = 1'b1; erase_kind_o = OP_CHIP;
            end else if (wdata_i == K_BLOCK) begin
              ev_erase_o = 1'b1; erase_kind_o = OP_BLOCK;
            end else if (at_a1 && wdata_i == K_PROT) begin
              ev_erase_o = 1'b1; erase_kind_o = OP_PROT;
            end
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= SQ_IDLE;
    else if (!en_i) st_q <= SQ_IDLE;
    else            st_q <= st_d;
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && cnt_q == '0) cnt_q <= LOAD;
    else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_id_table.sv
module flash_id_table #(
  parameter logic [7:0] ID_TYPE   = 8'h41,
  parameter logic [7:0] ID_MAKER  = 8'h98,
  parameter logic [7:0] ID_DEVICE = 8'h5A,
  parameter logic [7:0] ID_MACRO  = 8'hC3
) (
  input  logic [1:0] sel_i,
  output logic [7:0] code_o
);
  localparam logic [7:0] TBL [4] = '{ID_TYPE, ID_MAKER, ID_DEVICE, ID_MACRO};
  assign code_o = TBL[sel_i];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] UNLOCK_A1 = AW'(16'h5555),
  parameter logic [AW-1:0] UNLOCK_A2 = AW'(16'h2AAA),
  parameter int unsigned ERASE_CYCLES = 20,
  parameter logic [7:0] ID_TYPE   = 8'h41,
  parameter logic [7:0] ID_MAKER  = 8'h98,
  parameter logic [7:0] ID_DEVICE = 8'h5A,
  parameter logic [7:0] ID_MACRO  = 8'hC3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    array_data_i,
  output logic [7:0]    rdata_o,
  output logic          ready_o,
  output logic [1:0]    erase_op_o,
  output logic          id_mode_o
);
  logic      ev_reset, ev_id, ev_erase, ev_other;
  erase_op_e erase_kind;
  logic      busy, done;
  rd_mode_e  mode_q;
  logic [1:0] sel_q;
  erase_op_e op_q;
  logic [7:0] id_code, status, rdata_q;

  flash_seq_match #(.AW(AW), .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)) u_seq (
    .clk_i, .rst_ni,
    .en_i        (!busy),
    .wr_i, .addr_i, .wdata_i,
    .ev_reset_o  (ev_reset),
    .ev_id_o     (ev_id),
    .ev_erase_o  (ev_erase),
    .erase_kind_o(erase_kind),
    .ev_other_o  (ev_other)
  );

  flash_erase_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i(ev_erase),
    .busy_o (busy),
    .done_o (done)
  );

  flash_id_table #(.ID_TYPE(ID_TYPE), .ID_MAKER(ID_MAKER),
                   .ID_DEVICE(ID_DEVICE), .ID_MACRO(ID_MACRO)) u_id (
    .sel_i (sel_q),
    .code_o(id_code)
  );

  assign status = {~busy, 5'b0, op_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_ARRAY;
      sel_q   <= 2'd0;
      op_q    <= OP_NONE;
      rdata_q <= 8'h00;
    end else begin
      if (ev_erase) op_q <= erase_kind;
      else if (done) op_q <= OP_NONE;

      if (ev_reset || ev_erase) mode_q <= MD_ARRAY;
      else if (ev_id) begin
        mode_q <= MD_ID;
        sel_q  <= 2'd0;
      end else if (ev_other && mode_q == MD_ID) sel_q <= wdata_i[1:0];

      if (rd_i) begin
        if (busy)                rdata_q <= status;
        else if (mode_q == MD_ID) rdata_q <= id_code;
        else                     rdata_q <= array_data_i;
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign ready_o    = ~busy;
  assign erase_op_o = op_q;
  assign id_mode_o  = (mode_q == MD_ID);
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned ERASE_CYCLES = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          ready_o,
  input logic [1:0]    erase_op_o,
  input logic          id_mode_o
);
  localparam int unsigned RW = $clog2(ERASE_CYCLES + 2) + 1;
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_run <= '0;
    else if (ready_o) busy_run <= '0;
    else              busy_run <= busy_run + 1'b1;
  end

  AST_BUSY_HAS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> erase_op_o != 2'd0); // R8
  AST_READY_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> erase_op_o == 2'd0); // R8
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= RW'(ERASE_CYCLES)); // R8
  AST_BUSY_NOT_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !id_mode_o); // R9
  AST_OP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o || $stable(erase_op_o)); // R9
  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ready_o) |=> rdata_o == {6'b0, $past(erase_op_o)}); // R10
  AST_F0_EXITS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && wdata_i == 8'hF0) |=> !id_mode_o); // R7
  AST_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |-> !$isunknown(addr_i)); // R2
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.AW(AW), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ready_o(ready_o),
  .erase_op_o(erase_op_o), .id_mode_o(id_mode_o)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int N = 20;
  localparam logic [7:0] IDV [4] = '{8'h41, 8'h98, 8'h5A, 8'hC3};

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0, array_data_i, rdata_o;
  logic ready_o, id_mode_o;
  logic [1:0] erase_op_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] arr(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign array_data_i = arr(addr_i);

  flash_cmd_ctrl dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .array_data_i,
    .rdata_o, .ready_o, .erase_op_o, .id_mode_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    chk(req, int'(rdata_o), int'(exp));
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic enter_id();
    unlock(); wr(16'h5555, 8'h90);
  endtask

  task automatic erase_seq(input logic [15:0] a, input logic [7:0] d);
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(a, d);
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready_o, 1); chk("R1 op", erase_op_o, 0); chk("R1 id", id_mode_o, 0);
    rd(16'h0100, arr(16'h0100), "R1 read");
    // R2 array read sweep
    for (int i = 0; i < 16; i++) rd(16'(i * 16'h0ABC + 3), arr(16'(i * 16'h0ABC + 3)), "R2");

    // R3 ID entry, default type code
    enter_id();
    chk("R3 id mode", id_mode_o, 1);
    for (int i = 0; i < 4; i++) rd(16'(i * 16'h1111), IDV[0], "R3");

    // R4 repeated code selects
    for (int rep = 0; rep < 3; rep++)
      for (int s = 0; s < 4; s++) begin
        wr(16'(16'h0200 + rep * 7 + s), 8'(8'h04 * rep + s));
        rd(16'(16'h3000 + s * 16'h0101), IDV[s], "R4");
      end
    // R5 persistence and exits
    chk("R5 still id", id_mode_o, 1);
    wr(16'h0000, 8'hF0);
    chk("R5 F0 exit", id_mode_o, 0);
    rd(16'h1234, arr(16'h1234), "R5 array after F0");
    enter_id(); wr(16'h0001, 8'h02);
    unlock(); wr(16'h5555, 8'hF0);
    chk("R5 3cyc exit", id_mode_o, 0);
    rd(16'h4321, arr(16'h4321), "R5 array after 3cyc");
    enter_id(); hw_reset();
    chk("R5 hw exit", id_mode_o, 0);
    rd(16'h0777, arr(16'h0777), "R5 array after hw reset");

    // R6 mismatch
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'h90);
    chk("R6 bad addr no id", id_mode_o, 0);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(16'h5555, 8'h90);
    chk("R6 bad data no id", id_mode_o, 0);
    enter_id(); wr(16'h0010, 8'h03);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h33);
    chk("R6 stays id", id_mode_o, 1);
    rd(16'h0020, IDV[3], "R6 sel kept");

    // R7 cancel
    unlock(); wr(16'h0000, 8'hF0);
    chk("R7 id cancel", id_mode_o, 0);
    unlock(); wr(16'h5555, 8'h80); wr(16'h5555, 8'hAA); wr(16'h0003, 8'hF0);
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
    chk("R7 erase cancelled", ready_o, 1);
    wr(16'h5555, 8'h90);
    chk("R7 idle after cancel", id_mode_o, 0);

    // R8 each erase kind, block from ID mode
    for (int k = 1; k <= 3; k++) begin
      if (k == 2) enter_id();
      case (k)
        1: erase_seq(16'h5555, 8'h10);
        2: erase_seq(16'h7000, 8'h30);
        default: erase_seq(16'h5555, 8'h60);
      endcase
      t0 = cyc;
      chk("R8 busy", ready_o, 0); chk("R8 op", erase_op_o, k);
      while (!ready_o) @(negedge clk);
      chk("R8 length", cyc - t0, N);
      chk("R8 op clear", erase_op_o, 0); chk("R8 read mode", id_mode_o, 0);
      rd(16'h0ABC, arr(16'h0ABC), "R8 array after");
    end

    // R9 / R10 writes ignored, status reads while busy
    erase_seq(16'h5555, 8'h60);
    t0 = cyc;
    rd(16'h0100, 8'h03, "R10 status");
    wr(16'h0000, 8'hF0);
    enter_id();
    chk("R9 no id while busy", id_mode_o, 0);
    rd(16'h0200, 8'h03, "R10 status again");
    chk("R9 op kept", erase_op_o, 3);
    while (!ready_o) @(negedge clk);
    chk("R9 full length", cyc - t0, N);
    chk("R9 id not entered", id_mode_o, 0);
    wr(16'h5555, 8'h90);
    chk("R9 matcher idle", id_mode_o, 0);
    rd(16'h0055, arr(16'h0055), "R9 array after");

    // R11 abort
    erase_seq(16'h2000, 8'h30);
    repeat (5) @(negedge clk);
    chk("R11 busy before", ready_o, 0);
    rst_ni = 1'b0;
    #1;
    chk("R11 ready", ready_o, 1); chk("R11 op", erase_op_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(16'h0999, arr(16'h0999), "R11 array");
    finish_run();
  end
endmodule